// File: doc/BRIEF.md
# SIMD Single-Lane Transfer Decoder

This block examines a 32-bit instruction word and decides whether it belongs to the SIMD class that moves one element between memory and a single lane of one to four vector registers. When the word is in that class, the block pulls out every field an execution stage needs: the direction, the base and index general registers, the first vector register, the element size, the register count, the lane number, the alignment hint and the register stride. It also raises an undefined-instruction flag for every illegal combination of count, size and alignment hint, for a register group that runs past the last vector register, and for a reference to the upper half of the register file when that half is not fitted.

The word is presented together with a valid strobe. One clock later every output is registered and `out_valid` pulses. A configuration input tells the block whether 32 or only 16 vector registers exist. Words from any other instruction class yield a no-match result with all fields zero. The block does not perform the transfer and does not check the run-time address.

Top module: `lane_xfer_decoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and all other outputs update in that same cycle. After reset every output is zero.
- R2: A word matches only when bits [31:24] equal 0xF4, bit 23 is 1, bit 20 is 0 and bits [11:10] are not 3. A word that does not match gives `out_match`=0, `out_undef`=0 and every field output zero.
- R3: On a match, `out_is_load` is bit 21 (1 means load), `out_base` is bits [19:16], `out_index` is bits [3:0], `out_size` is bits [11:10] (0 byte, 1 halfword, 2 word), `out_count` is bits [9:8] plus one, and `out_vreg` is bit 22 above bits [15:12].
- R4: For size 0, `out_lane` is bits [7:5], `out_align` is bit 4 zero-extended, and `out_stride` is 1.
- R5: For size 1, `out_lane` is bits [7:6], `out_align` is bits [5:4], and `out_stride` is 2 when bit 5 is set and 1 otherwise.
- R6: For size 2, `out_lane` is bit 7, `out_align` is bits [6:4], and `out_stride` is 2 when bit 6 is set and 1 otherwise.
- R7: With a count of one, the word is undefined when alignment bit number `size` is set, or when size is 2 and alignment bits [1:0] are 01 or 10.
- R8: With a count of two or three, the word is undefined when size is 2 and alignment bit 1 is set; with a count of three it is also undefined when alignment bit 0 is set.
- R9: With a count of four, the word is undefined only when size is 2 and alignment bits [1:0] are 11 (among the alignment rules).
- R10: The word is undefined when first register plus stride times (count minus one) is above 31.
- R11: When `cfg_upper_regs` is 0, a word whose first vector register has bit 4 set is undefined; when it is 1 that bit causes nothing.
- R12: In a cycle after one with `in_valid` low, `out_valid` is 0 and every other output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_instr` is to be decoded |
| in_instr | input | 32 | Instruction word |
| cfg_upper_regs | input | 1 | 1 when vector registers 16 to 31 exist |
| out_valid | output | 1 | Decode result is new this cycle |
| out_match | output | 1 | Word belongs to the single-lane transfer class |
| out_undef | output | 1 | Matched word is an undefined instruction |
| out_is_load | output | 1 | 1 load, 0 store |
| out_base | output | 4 | Base address register |
| out_index | output | 4 | Index register |
| out_vreg | output | 5 | First vector register |
| out_size | output | 2 | Element size code |
| out_count | output | 3 | Number of registers, 1 to 4 |
| out_lane | output | 3 | Lane number |
| out_align | output | 3 | Alignment hint bits |
| out_stride | output | 2 | Register step, 1 or 2 |

## Verification
The bench sweeps every size, count and upper-nibble value, so a design that split the shared nibble at the wrong point for one size would show a shifted lane or a stride taken from the wrong bit. The count-three case, which adds the bit-0 rule on top of the count-two rule, catches a design that treats counts two and three alike. Register groups ending exactly at 31 and one past it expose an off-by-one comparison, and first register 16 with the upper half absent catches a missing or inverted configuration check. Words one bit away from the class pattern, including size code 3, catch an over-wide match that would leak fields or an undefined flag.

// File: rtl/lxd_pkg.sv
package lxd_pkg;

   localparam int INSN_BITS = 32;
   localparam int GPR_BITS  = 4;
   localparam int VREG_BITS = 5;
   localparam int LANE_BITS = 3;
   localparam logic [7:0] OPC_TOP = 8'hF4;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_WORD = 2'd2,
      ESZ_RSVD = 2'd3
   } elem_size_e;

   typedef struct packed {
      logic                  is_load;
      logic [GPR_BITS-1:0]   base;
      logic [GPR_BITS-1:0]   index;
      logic [VREG_BITS-1:0]  vreg;
      elem_size_e            size;
      logic [2:0]            count;
      logic [LANE_BITS-1:0]  lane;
      logic [LANE_BITS-1:0]  align;
      logic [1:0]            stride;
   } lxd_fields_t;

endpackage

// File: rtl/lxd_field_split.sv
module lxd_field_split
   import lxd_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic [INSN_W-1:0] instr,
   output logic              hit,
   output lxd_fields_t       fld
);
   localparam int NUM_SIZES = 3;

   logic [3:0]           nib;
   logic [LANE_BITS-1:0] lane_c   [NUM_SIZES];
   logic [LANE_BITS-1:0] align_c  [NUM_SIZES];
   logic [1:0]           stride_c [NUM_SIZES];

   assign nib = instr[7:4];

   // The same nibble is cut at a size-dependent point: lanes above, hint below.
   generate
      for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
         assign lane_c[gs]  = LANE_BITS'(nib >> (gs + 1));
         assign align_c[gs] = LANE_BITS'(nib & 4'((8'd2 << gs) - 8'd1));
         if (gs == 0) begin : g_unit
            assign stride_c[gs] = 2'd1;
         end else begin : g_sel
            assign stride_c[gs] = {1'b0, nib[gs]} + 2'd1;
         end
      end
   endgenerate

   always_comb begin
      hit = (instr[31:24] == OPC_TOP) && instr[23] && !instr[20]
            && (instr[11:10] != 2'b11);
      fld = '0;
      if (hit) begin
         fld.is_load = instr[21];
         fld.base    = instr[19:16];
         fld.index   = instr[3:0];
         fld.vreg    = {instr[22], instr[15:12]};
         fld.size    = elem_size_e'(instr[11:10]);
         fld.count   = {1'b0, instr[9:8]} + 3'd1;
         case (instr[11:10])
            2'd0: begin
               fld.lane = lane_c[0]; fld.align = align_c[0]; fld.stride = stride_c[0];
            end
            2'd1: begin
               fld.lane = lane_c[1]; fld.align = align_c[1]; fld.stride = stride_c[1];
            end
            default: begin
               fld.lane = lane_c[2]; fld.align = align_c[2]; fld.stride = stride_c[2];
            end
         endcase
      end
   end
endmodule

// File: rtl/lxd_legality.sv
module lxd_legality
   import lxd_pkg::*;
#(
   parameter int VREG_W = 5
) (
   input  logic        hit,
   input  lxd_fields_t fld,
   input  logic        upper_present,
   output logic        undef
);
   localparam int SUM_W    = VREG_W + 2;
   localparam int MAX_VREG = (1 << VREG_W) - 1;

   logic [1:0]       extra;
   logic [SUM_W-1:0] last_reg;
   logic             bad_hint;
   logic             bad_range;
   logic             bad_bank;
   logic             is_word;

   assign extra    = fld.count[1:0] - 2'd1;
   assign is_word  = (fld.size == ESZ_WORD);
   assign last_reg = SUM_W'(fld.vreg) + SUM_W'(fld.stride) * SUM_W'(extra);

   always_comb begin
      bad_hint = 1'b0;
      case (extra)
         2'd0: bad_hint = fld.align[fld.size[1:0]]
                          || (is_word && (fld.align[1] ^ fld.align[0]));
         2'd1: bad_hint = is_word && fld.align[1];
         2'd2: bad_hint = fld.align[0] || (is_word && fld.align[1]);
         default: bad_hint = is_word && (fld.align[1:0] == 2'b11);
      endcase
   end

   assign bad_range = (last_reg > SUM_W'(MAX_VREG));
   assign bad_bank  = !upper_present && fld.vreg[VREG_W-1];
   assign undef     = hit && (bad_hint || bad_range || bad_bank);
endmodule

// File: rtl/lxd_out_stage.sv
module lxd_out_stage
   import lxd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_en,
   input  logic        d_hit,
   input  logic        d_undef,
   input  lxd_fields_t d_fld,
   output logic        q_valid,
   output logic        q_hit,
   output logic        q_undef,
   output lxd_fields_t q_fld
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_hit   <= 1'b0;
         q_undef <= 1'b0;
         q_fld   <= '0;
      end else begin
         q_valid <= load_en;
         if (load_en) begin
            q_hit   <= d_hit;
            q_undef <= d_undef;
            q_fld   <= d_fld;
         end
      end
   end
endmodule

// File: rtl/lane_xfer_decoder.sv
module lane_xfer_decoder
   import lxd_pkg::*;
#(
   parameter int INSN_W = INSN_BITS,
   parameter int GPR_W  = GPR_BITS,
   parameter int VREG_W = VREG_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_instr,
   input  logic              cfg_upper_regs,
   output logic              out_valid,
   output logic              out_match,
   output logic              out_undef,
   output logic              out_is_load,
   output logic [GPR_W-1:0]  out_base,
   output logic [GPR_W-1:0]  out_index,
   output logic [VREG_W-1:0] out_vreg,
   output logic [1:0]        out_size,
   output logic [2:0]        out_count,
   output logic [2:0]        out_lane,
   output logic [2:0]        out_align,
   output logic [1:0]        out_stride
);
   generate
      if (INSN_W != INSN_BITS || GPR_W != GPR_BITS || VREG_W != VREG_BITS) begin : g_bad_cfg
         $error("lane_xfer_decoder: widths must match the encoding");
      end
   endgenerate

   logic        dec_hit;
   logic        dec_undef;
   lxd_fields_t dec_fld;
   logic        reg_hit;
   logic        reg_undef;
   lxd_fields_t reg_fld;

   lxd_field_split #(.INSN_W(INSN_W)) u_split (
      .instr (in_instr),
      .hit   (dec_hit),
      .fld   (dec_fld)
   );

   lxd_legality #(.VREG_W(VREG_W)) u_legal (
      .hit           (dec_hit),
      .fld           (dec_fld),
      .upper_present (cfg_upper_regs),
      .undef         (dec_undef)
   );

   lxd_out_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (in_valid),
      .d_hit   (dec_hit),
      .d_undef (dec_undef),
      .d_fld   (dec_fld),
      .q_valid (out_valid),
      .q_hit   (reg_hit),
      .q_undef (reg_undef),
      .q_fld   (reg_fld)
   );

   assign out_match   = reg_hit;
   assign out_undef   = reg_undef;
   assign out_is_load = reg_fld.is_load;
   assign out_base    = reg_fld.base;
   assign out_index   = reg_fld.index;
   assign out_vreg    = reg_fld.vreg;
   assign out_size    = reg_fld.size;
   assign out_count   = reg_fld.count;
   assign out_lane    = reg_fld.lane;
   assign out_align   = reg_fld.align;
   assign out_stride  = reg_fld.stride;
endmodule

// File: rtl/lxd_checker.sv
module lxd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] in_instr,
   input logic        cfg_upper_regs,
   input logic        out_valid,
   input logic        out_match,
   input logic        out_undef,
   input logic        out_is_load,
   input logic [3:0]  out_base,
   input logic [3:0]  out_index,
   input logic [4:0]  out_vreg,
   input logic [1:0]  out_size,
   input logic [2:0]  out_count,
   input logic [2:0]  out_lane,
   input logic [2:0]  out_align,
   input logic [1:0]  out_stride
);
   logic [6:0] span_end;
   assign span_end = 7'(out_vreg) + 7'(out_stride) * 7'(out_count - 3'd1);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_match) && $stable(out_vreg)
                     && $stable(out_undef)));

   assert_undef_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> out_match);

   assert_size_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_match |-> (out_size != 2'd3 && out_count != 3'd0 && out_count <= 3'd4));

   assert_byte_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_match && out_size == 2'd0) |-> (out_stride == 2'd1 && out_align[2:1] == 2'b00));

   assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_match && !out_undef) |-> (span_end <= 7'd31));

   assert_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_upper_regs) |=> !(out_match && !out_undef && out_vreg[4]));
endmodule

bind lane_xfer_decoder lxd_checker u_lxd_checker (.*);

// File: tb/tb_lane_xfer_decoder.sv
module tb_lane_xfer_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic        cfg_upper_regs = 1'b1;
   logic        out_valid, out_match, out_undef, out_is_load;
   logic [3:0]  out_base, out_index;
   logic [4:0]  out_vreg;
   logic [1:0]  out_size, out_stride;
   logic [2:0]  out_count, out_lane, out_align;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lane_xfer_decoder dut (.*);

   wire [29:0] act_v = {out_valid, out_match, out_undef, out_is_load, out_base, out_index,
                        out_vreg, out_size, out_count, out_lane, out_align, out_stride};

   function automatic logic [31:0] mk(input logic ld, input logic [4:0] vr, input logic [3:0] rn,
                                      input logic [3:0] rm, input logic [1:0] sz,
                                      input logic [1:0] n, input logic [3:0] nib);
      return {8'hF4, 1'b1, vr[4], ld, 1'b0, rn, vr[3:0], sz, n, nib, rm};
   endfunction

   // Expected result written from the requirements (R2..R11).
   function automatic logic [28:0] model(input logic [31:0] w, input logic up);
      logic [1:0] sz, st, n;
      logic [2:0] ln, al;
      logic [4:0] vr;
      logic bad;
      int last;
      if (!(w[31:24] == 8'hF4 && w[23] && !w[20] && w[11:10] != 2'b11)) return '0;
      sz = w[11:10]; n = w[9:8]; vr = {w[22], w[15:12]};
      if (sz == 2'd0) begin ln = w[7:5]; al = {2'b00, w[4]}; st = 2'd1; end
      else if (sz == 2'd1) begin ln = {1'b0, w[7:6]}; al = {1'b0, w[5:4]}; st = w[5] ? 2'd2 : 2'd1; end
      else begin ln = {2'b00, w[7]}; al = w[6:4]; st = w[6] ? 2'd2 : 2'd1; end
      case (n)
         2'd0: bad = al[sz] || (sz == 2'd2 && (al[1:0] == 2'b01 || al[1:0] == 2'b10));
         2'd1: bad = (sz == 2'd2) && al[1];
         2'd2: bad = al[0] || ((sz == 2'd2) && al[1]);
         default: bad = (sz == 2'd2) && (al[1:0] == 2'b11);
      endcase
      last = int'(vr) + int'(st) * int'(n);
      if (last > 31) bad = 1'b1;
      if (!up && vr[4]) bad = 1'b1;
      return {1'b1, bad, w[21], w[19:16], w[3:0], vr, sz, {1'b0, n} + 3'd1, ln, al, st};
   endfunction

   task automatic check(input string tag, input logic [29:0] act, input logic [29:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [31:0] w, input logic up, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_instr = w; cfg_upper_regs = up;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, act_v, {1'b1, model(w, up)});
   endtask

   task automatic t_reset();
      check("R1 reset", act_v, '0);
   endtask

   task automatic t_nomatch();
      logic [31:0] good;
      good = mk(1'b1, 5'd3, 4'd5, 4'd7, 2'd1, 2'd1, 4'b1010);
      run(good ^ 32'h0010_0000, 1'b1, "R2 bit20 set");
      run(good ^ 32'h0080_0000, 1'b1, "R2 bit23 clear");
      run(good ^ 32'h0100_0000, 1'b1, "R2 top byte");
      run(mk(1'b1, 5'd3, 4'd5, 4'd7, 2'd3, 2'd1, 4'b1010), 1'b1, "R2 size3");
      run(good, 1'b1, "R2 match");
   endtask

   task automatic t_fields();
      run(mk(1'b1, 5'd9, 4'd12, 4'd13, 2'd0, 2'd0, 4'b0110), 1'b1, "R3 load");
      run(mk(1'b0, 5'd20, 4'd3, 4'd15, 2'd1, 2'd3, 4'b0000), 1'b1, "R3 store high vreg");
      run(mk(1'b1, 5'd0, 4'd15, 4'd0, 2'd2, 2'd1, 4'b1000), 1'b1, "R3 word");
   endtask

   task automatic t_size_sweep(input logic [1:0] sz, input string tag);
      for (int nib = 0; nib < 16; nib++)
         run(mk(1'b1, 5'd4, 4'd1, 4'd2, sz, 2'd1, 4'(nib)), 1'b1, tag);
   endtask

   task automatic t_count_sweep(input logic [1:0] n, input string tag);
      for (int sz = 0; sz < 3; sz++)
         for (int nib = 0; nib < 16; nib++)
            run(mk(1'b0, 5'd2, 4'd6, 4'd13, 2'(sz), n, 4'(nib)), 1'b1, tag);
   endtask

   task automatic t_range();
      run(mk(1'b1, 5'd29, 4'd0, 4'd0, 2'd0, 2'd2, 4'b0000), 1'b1, "R10 ends at 31");
      run(mk(1'b1, 5'd30, 4'd0, 4'd0, 2'd0, 2'd2, 4'b0000), 1'b1, "R10 past 31");
      run(mk(1'b1, 5'd30, 4'd0, 4'd0, 2'd1, 2'd1, 4'b0010), 1'b1, "R10 stride2 past");
      run(mk(1'b1, 5'd29, 4'd0, 4'd0, 2'd2, 2'd1, 4'b0100), 1'b1, "R10 stride2 at 31");
      run(mk(1'b1, 5'd31, 4'd0, 4'd0, 2'd0, 2'd0, 4'b0000), 1'b1, "R10 single at 31");
   endtask

   task automatic t_bank();
      run(mk(1'b1, 5'd16, 4'd0, 4'd0, 2'd0, 2'd0, 4'b0000), 1'b0, "R11 upper absent");
      run(mk(1'b1, 5'd16, 4'd0, 4'd0, 2'd0, 2'd0, 4'b0000), 1'b1, "R11 upper present");
      run(mk(1'b1, 5'd15, 4'd0, 4'd0, 2'd0, 2'd0, 4'b0000), 1'b0, "R11 lower bank");
   endtask

   task automatic t_hold();
      logic [31:0] w;
      w = mk(1'b1, 5'd7, 4'd9, 4'd4, 2'd1, 2'd0, 4'b1100);
      run(w, 1'b1, "R12 setup");
      @(negedge clk);
      in_instr = mk(1'b0, 5'd1, 4'd2, 4'd3, 2'd0, 2'd3, 4'b1111);
      cfg_upper_regs = 1'b0;
      @(negedge clk);
      check("R12 hold", act_v, {1'b0, model(w, 1'b1)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_nomatch();
      t_fields();
      t_size_sweep(2'd0, "R4 byte split");
      t_size_sweep(2'd1, "R5 half split");
      t_size_sweep(2'd2, "R6 word split");
      t_count_sweep(2'd0, "R7 one reg");
      t_count_sweep(2'd1, "R8 two regs");
      t_count_sweep(2'd2, "R8 three regs");
      t_count_sweep(2'd3, "R9 four regs");
      t_range();
      t_bank();
      t_hold();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule